// File: doc/BRIEF.md
# Clock Source Switchover Sequencer

This block keeps a processor clock running on a steady source while the PLL upstream of it is retuned. It owns a small control register that holds two mux select bits. The output select picks either the crystal or the divider path as the processor clock. The divider-source select picks either the crystal or the PLL as the input of the divider. The remaining bits of the register belong to neighbouring logic.

Before the PLL is reprogrammed, the system raises `pre_req`. The sequencer moves the output select onto the crystal at once. It then counts a settling interval in crystal cycles, and only after that does it point the divider at the PLL. Once the PLL has relocked, the system raises `post_req`. The sequencer returns the processor clock to the divider path and waits one more settling interval. `busy` covers each sequence from the edge that accepts the request to the end of its wait, and `done` marks the end of the sequence.

Neighbouring logic updates the other register bits through `side_we`. That write path never touches the two mux bits. The sequencer never touches the other bits.

Top module: `clksw_seq`

## Requirements
- R1: Reset state. After reset, `ctrl` equals RST_VAL with bit 7 (output select) and bit 0 (divider-source select) both forced to 0, which means crystal everywhere. `busy` and `done` are both 0.
- R2: Pre-change request. When `pre_req` is sampled high while idle, bit 7 is cleared at that same edge and `busy` rises at that edge. Bit 0 is unchanged at that point.
- R3: Pre-change ordering. Bit 0 is set exactly SETTLE_CYC cycles after the edge that cleared bit 7, and not before.
- R4: Post-change request. When `post_req` alone is sampled high while idle, bit 7 is set at that edge. `busy` stays high for exactly SETTLE_CYC cycles.
- R5: Completion. At the end of every sequence, `done` is high for exactly one cycle, on the same edge at which `busy` falls.
- R6: Requests that arrive while `busy` is high are ignored. They do not move bit 7, they do not stretch the wait, and they are not queued.
- R7: When `pre_req` and `post_req` are sampled high together while idle, the pre-change sequence runs.
- R8: Other bits are preserved. A `side_we` write loads only the bits other than 7 and 0. Without such a write, those bits hold their value through every sequence.
- R9: Bit 0 never falls except at reset, and it rises only together with `done`. A post-change sequence leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock that runs the sequencer and its settling counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_req | input | 1 | Start the pre-retune sequence |
| post_req | input | 1 | Start the post-retune sequence |
| side_we | input | 1 | Write enable for the bits other than the mux bits |
| side_wdata | input | CTRL_W | Write data; bits 7 and 0 are discarded |
| ctrl | output | CTRL_W | Control register: bit 7 output select, bit 0 divider-source select |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench times the divider-source switch against the edge that cleared the output select. A counter that is off by one would switch the divider one cycle early or one cycle late, and so would `done`. It fires both requests at once and in the middle of a wait. A design without a priority would run the post sequence, and a design that queued requests would run a second sequence or stretch `busy`. It writes the neighbouring bits during a sequence and together with a request. A design that merged the writes wrongly would lose a mux bit or would let the write reach bits 7 and 0. It also resets in the middle of a wait, which must return the register to all-crystal.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PRE_WAIT  = 2'd1,
        ST_POST_WAIT = 2'd2
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    done;
    } fsm_reg_s;

    // one-hot style commands from the sequencer to the register
    typedef struct packed {
        logic clr_out;
        logic set_out;
        logic set_div;
    } mux_cmd_s;

endpackage

// File: rtl/clksw_timer.sv
module clksw_timer #(
    parameter int SETTLE_CYC = 2400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = LOAD_VAL;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == '0);

endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
    import clksw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pre_req,
    input  logic     post_req,
    input  logic     expired,
    output logic     tmr_load,
    output logic     tmr_run,
    output mux_cmd_s cmd,
    output logic     busy,
    output logic     done
);
    fsm_reg_s r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_run  = 1'b0;
        cmd      = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                // pre-change wins when both arrive together
                if (pre_req) begin
                    cmd.clr_out = 1'b1;
                    tmr_load    = 1'b1;
                    r_d.st      = ST_PRE_WAIT;
                end else if (post_req) begin
                    cmd.set_out = 1'b1;
                    tmr_load    = 1'b1;
                    r_d.st      = ST_POST_WAIT;
                end
            end
            ST_PRE_WAIT: begin
                tmr_run = 1'b1;
                if (expired) begin
                    cmd.set_div = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.st      = ST_IDLE;
                end
            end
            ST_POST_WAIT: begin
                tmr_run = 1'b1;
                if (expired) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int               CTRL_W  = 8,
    parameter int               OUT_BIT = 7,
    parameter int               DIV_BIT = 0,
    parameter logic [CTRL_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mux_cmd_s          cmd,
    input  logic              side_we,
    input  logic [CTRL_W-1:0] side_wdata,
    output logic [CTRL_W-1:0] ctrl
);
    localparam logic [CTRL_W-1:0] MUX_MASK =
        (CTRL_W'(1) << OUT_BIT) | (CTRL_W'(1) << DIV_BIT);
    localparam logic [CTRL_W-1:0] RST_SAFE = RST_VAL & ~MUX_MASK;

    logic [CTRL_W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (side_we) begin
            reg_d = (reg_q & MUX_MASK) | (side_wdata & ~MUX_MASK);
        end
        if (cmd.clr_out) reg_d[OUT_BIT] = 1'b0;
        if (cmd.set_out) reg_d[OUT_BIT] = 1'b1;
        if (cmd.set_div) reg_d[DIV_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= RST_SAFE;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign ctrl = reg_q;

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
#(
    parameter int               CTRL_W     = 8,
    parameter int               OUT_BIT    = 7,
    parameter int               DIV_BIT    = 0,
    parameter int               SETTLE_CYC = 2400,
    parameter logic [CTRL_W-1:0] RST_VAL    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_req,
    input  logic              post_req,
    input  logic              side_we,
    input  logic [CTRL_W-1:0] side_wdata,
    output logic [CTRL_W-1:0] ctrl,
    output logic              busy,
    output logic              done
);
    logic     tmr_load, tmr_run, tmr_exp;
    mux_cmd_s cmd;

    clksw_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .run    (tmr_run),
        .expired(tmr_exp)
    );

    clksw_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_req (pre_req),
        .post_req(post_req),
        .expired (tmr_exp),
        .tmr_load(tmr_load),
        .tmr_run (tmr_run),
        .cmd     (cmd),
        .busy    (busy),
        .done    (done)
    );

    clksw_ctrl #(
        .CTRL_W (CTRL_W),
        .OUT_BIT(OUT_BIT),
        .DIV_BIT(DIV_BIT),
        .RST_VAL(RST_VAL)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .side_we   (side_we),
        .side_wdata(side_wdata),
        .ctrl      (ctrl)
    );

endmodule

// File: rtl/clksw_chk.sv
module clksw_chk #(
    parameter int CTRL_W     = 8,
    parameter int OUT_BIT    = 7,
    parameter int DIV_BIT    = 0,
    parameter int SETTLE_CYC = 2400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pre_req,
    input logic              post_req,
    input logic              side_we,
    input logic [CTRL_W-1:0] ctrl,
    input logic              busy,
    input logic              done
);
    localparam logic [CTRL_W-1:0] KEEP =
        ~((CTRL_W'(1) << OUT_BIT) | (CTRL_W'(1) << DIV_BIT));
    localparam int WW = $clog2(SETTLE_CYC + 2);

    logic [WW-1:0] win_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    win_q <= '0;
        else if (busy) win_q <= win_q + 1'b1;
        else           win_q <= '0;
    end

    // R2
    pre_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pre_req) |=> (!ctrl[OUT_BIT] && busy));
    // R4
    post_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !pre_req && post_req) |=> (ctrl[OUT_BIT] && busy));
    // R3
    settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (win_q == WW'(SETTLE_CYC)));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    done_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctrl[OUT_BIT]));
    // R8
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !side_we |=> ((ctrl & KEEP) == ($past(ctrl) & KEEP)));
    // R9
    div_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ctrl[DIV_BIT]));
    // R9
    div_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl[DIV_BIT]) |-> done);

endmodule

bind clksw_seq clksw_chk #(
    .CTRL_W    (CTRL_W),
    .OUT_BIT   (OUT_BIT),
    .DIV_BIT   (DIV_BIT),
    .SETTLE_CYC(SETTLE_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pre_req (pre_req),
    .post_req(post_req),
    .side_we (side_we),
    .ctrl    (ctrl),
    .busy    (busy),
    .done    (done)
);

// File: tb/sim_clksw_seq.sv
module sim_clksw_seq;
    localparam int   CLK_PERIOD = 10;
    localparam int   N          = 6;
    localparam logic [7:0] RSTV = 8'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_req = 1'b0, post_req = 1'b0, side_we = 1'b0;
    logic [7:0] side_wdata = '0;
    logic [7:0] ctrl;
    logic       busy, done;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksw_seq #(.CTRL_W(8), .OUT_BIT(7), .DIV_BIT(0),
                .SETTLE_CYC(N), .RST_VAL(RSTV)) u0 (
        .clk(clk), .rst_n(rst_n), .pre_req(pre_req), .post_req(post_req),
        .side_we(side_we), .side_wdata(side_wdata),
        .ctrl(ctrl), .busy(busy), .done(done)
    );

    // {op[1:0] (1 pre, 2 post, 3 both), side_we, side data, final ctrl}
    localparam logic [18:0] VEC [5] = '{
        {2'd1, 1'b0, 8'h00, 8'h5B},
        {2'd2, 1'b1, 8'h24, 8'hA5},
        {2'd1, 1'b1, 8'hFF, 8'h7F},
        {2'd3, 1'b0, 8'h00, 8'h7F},   // R7 both at once: pre wins
        {2'd2, 1'b1, 8'h00, 8'h81}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctrl", ctrl, 8'h5A);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", busy, 0);

        for (int i = 0; i < 5; i++) begin
            logic [1:0] op;
            logic [7:0] prev;
            op   = VEC[i][18:17];
            prev = ctrl;
            pre_req    = op[0];
            post_req   = op[1];
            side_we    = VEC[i][16];
            side_wdata = VEC[i][15:8];
            @(negedge clk);
            pre_req = 0; post_req = 0; side_we = 0;
            // R2 / R4 / R7 output select moves at acceptance
            check("R2 R4 R7 out select", ctrl[7], (op == 2'd2) ? 1 : 0);
            check("R2 R4 busy", busy, 1);
            check("R2 R9 div select unchanged", ctrl[0], prev[0]);
            repeat (N - 1) @(negedge clk);
            check("R3 no early done", done, 0);
            check("R3 div select not early", ctrl[0], prev[0]);
            @(negedge clk);
            check("R5 done", done, 1);
            check("R5 busy fell", busy, 0);
            check("R3 R8 R9 final ctrl", ctrl, VEC[i][7:0]);
            @(negedge clk);
            check("R5 done one cycle", done, 0);
        end

        // R6 requests during a wait are ignored (ctrl now 0x81)
        post_req = 1;
        @(negedge clk);
        post_req = 0;
        @(negedge clk);
        pre_req = 1; post_req = 1;
        @(negedge clk);
        pre_req = 0; post_req = 0;
        check("R6 out select held", ctrl[7], 1);
        repeat (N - 3) @(negedge clk);
        check("R6 wait not stretched pre", done, 0);
        @(negedge clk);
        check("R6 done on time", done, 1);
        @(negedge clk);
        check("R6 not queued", busy, 0);
        check("R6 ctrl", ctrl, 8'h81);

        // R8 side write during pre wait
        pre_req = 1;
        @(negedge clk);
        pre_req = 0;
        check("R2 out cleared", ctrl, 8'h01);
        side_we = 1; side_wdata = 8'hFE;
        @(negedge clk);
        side_we = 0;
        check("R8 write mid wait", ctrl, 8'h7F);
        repeat (N - 1) @(negedge clk);
        check("R8 R5 done", done, 1);
        check("R8 final", ctrl, 8'h7F);

        // R1 reset in the middle of a sequence
        post_req = 1;
        @(negedge clk);
        post_req = 0;
        @(negedge clk);
        rst_n = 0;
        #1;
        check("R1 mid reset ctrl", ctrl, 8'h5A);
        check("R1 mid reset busy", busy, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (N + 2) @(negedge clk);
        check("R1 stays idle", busy, 0);
        check("R1 no done", done, 0);
        finish_run();
    end
endmodule